// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside an I2C protocol engine and turns its one-cycle event pulses into sticky status flags. A mask register selects which flags may raise the single interrupt line. A vector register reports, as a small number, the most urgent pending source that is enabled. Software reads the vector, handles the reported source, and reads again until the vector returns zero. Each vector read clears the flag it reports, so a service loop drains all pending sources one by one.

Two level inputs from the engine are also shown in the status word: bus busy and receive shift register full. They are read-only, they never raise the interrupt and they never appear in the vector. The register port is a simple strobe interface. Read data is registered and is valid in the cycle after the read strobe.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset all event flags and the mask are zero, irq_o is low, and reads of status, mask and vector return 0.
- R2: A pulse on evt_i[k] sets status bit k on the next clock edge, whether or not it is masked. The bit order is: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: Status bit 12 shows busy_i and status bit 11 shows rsfull_i at the time of the read. Writes to these bits have no effect.
- R4: A write to status offset 0x08 clears every event flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: If an event pulse and a clear of the same flag fall in the same cycle, the flag stays set.
- R6: irq_o is high whenever some event flag is set and its mask bit is also set. It follows the flags and mask one cycle after the event or the register write. busy_i and rsfull_i never drive it.
- R7: The mask register is at offset 0x04, bits 6:0, in the same bit order as R2. It can be read and written.
- R8: A vector read at offset 0x28 returns the code of the pending enabled source with the lowest code. The codes are: arbitration lost 1, NACK 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed as slave 7.
- R9: A vector read returns 0 when no enabled flag is pending. A flag that is set but masked is not reported.
- R10: A vector read clears the flag it reports, so the next vector read reports the next source.
- R11: Read data appears in the cycle after reg_rd_i. A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | One-cycle event pulses, in the bit order of R2 |
| busy_i | input | 1 | Bus busy level from the protocol engine |
| rsfull_i | input | 1 | Receive shift register full level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the cycle after reg_rd_i |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A flag stuck or lost inside the unit shows up on the next status read, and when the source is enabled it also shows up on irq_o in the cycle after the event. A wrong priority or a vector read that fails to clear its flag shows up during a sequence of back-to-back vector reads. The sequence then returns the sources in the wrong order, repeats a code, or never reaches zero. The masked-source cases and the case where an event arrives in the same cycle as a clear expose faults in the gating and in the set-over-clear order. These faults show up within one read.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 16;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h08;
  localparam logic [REG_AW-1:0] OFS_VECTOR = 8'h28;
  localparam int unsigned BUSY_BIT   = 12;
  localparam int unsigned RSFULL_BIT = 11;
endpackage

// File: rtl/ivu_flag_bank.sv
module ivu_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flags_q[k] <= 1'b0;
      else if (set_i[k])    flags_q[k] <= 1'b1;  // set wins over clear
      else if (clr_i[k])    flags_q[k] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/ivu_prio_enc.sv
module ivu_prio_enc #(
  parameter int unsigned N  = 7,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  grant_o
);
  // lowest index wins; code is index + 1, 0 means none
  always_comb begin
    code_o  = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o     = CW'(i + 1);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import ivu_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned AW      = REG_AW,
  parameter int unsigned DW      = REG_DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               busy_i,
  input  logic               rsfull_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               irq_o
);
  localparam int unsigned CW = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] flags_q, mask_q, pend, grant, clr;
  logic [CW-1:0]      vec_code;
  logic [DW-1:0]      status_word, rdata_d, rdata_q;
  logic               wr_status, wr_mask, rd_vec;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DW-1:NUM_SRC];

  assign wr_status = reg_wr_i && (reg_addr_i == AW'(OFS_STATUS));
  assign wr_mask   = reg_wr_i && (reg_addr_i == AW'(OFS_MASK));
  assign rd_vec    = reg_rd_i && (reg_addr_i == AW'(OFS_VECTOR));

  assign clr = (wr_status ? reg_wdata_i[NUM_SRC-1:0] : '0)
             | (rd_vec    ? grant                    : '0);

  ivu_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_i),
    .clr_i   (clr),
    .flags_o (flags_q)
  );

  assign pend = flags_q & mask_q;

  ivu_prio_enc #(.N(NUM_SRC), .CW(CW)) u_prio (
    .req_i   (pend),
    .code_o  (vec_code),
    .grant_o (grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i[NUM_SRC-1:0];
  end

  always_comb begin
    status_word                      = '0;
    status_word[NUM_SRC-1:0]         = flags_q;
    status_word[RSFULL_BIT]          = rsfull_i;
    status_word[BUSY_BIT]            = busy_i;
  end

  always_comb begin
    rdata_d = '0;
    unique case (reg_addr_i)
      AW'(OFS_MASK):   rdata_d[NUM_SRC-1:0] = mask_q;
      AW'(OFS_STATUS): rdata_d              = status_word;
      AW'(OFS_VECTOR): rdata_d[CW-1:0]      = vec_code;
      default:         rdata_d              = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rdata_d;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = |pend;
endmodule

// File: rtl/ivu_chk.sv
module ivu_chk
  import ivu_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned AW      = REG_AW,
  parameter int unsigned DW      = REG_DW
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               reg_wr_i,
  input logic               reg_rd_i,
  input logic [AW-1:0]      reg_addr_i,
  input logic [DW-1:0]      reg_wdata_i,
  input logic [DW-1:0]      reg_rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] flags
);
  // R2 R5
  event_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  // R4
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == AW'(OFS_STATUS) && reg_wdata_i[NUM_SRC-1:0] == '1
     && evt_i == '0) |=> (flags == '0));

  // R6
  mask_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == AW'(OFS_MASK) && reg_wdata_i[NUM_SRC-1:0] == '0)
    |=> !irq_o);

  // R8 R9
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == AW'(OFS_VECTOR)) |=> (reg_rdata_o <= DW'(NUM_SRC)));

  // R10
  vec_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == AW'(OFS_VECTOR) && !reg_wr_i && evt_i == '0)
    |=> (reg_rdata_o == '0 || $countones(flags) < $countones($past(flags))));
endmodule

bind i2c_irq_vector ivu_chk #(.NUM_SRC(NUM_SRC), .AW(AW), .DW(DW)) u_ivu_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .flags       (flags_q)
);

// File: tb/test_i2c_irq_vector.sv
module test_i2c_irq_vector;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        busy = 1'b0, rsfull = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, failures = 0, cycles = 0;
  bit rd_seen = 1'b0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_vector i_i2c_irq_vector (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .busy_i(busy), .rsfull_i(rsfull),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata, e, t);
    end
  end

  task automatic write(input logic [7:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read(input logic [7:0] a, input logic [15:0] e, input string t);
    rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({15'b0, irq}, 16'h0, "R1 irq");
    read(8'h08, 16'h0000, "R1 status");
    read(8'h04, 16'h0000, "R1 mask");
    read(8'h28, 16'h0000, "R1 vector");

    // R7 R2 R6 R8 R10: two sources, walk the vector
    write(8'h04, 16'h007f);
    read(8'h04, 16'h007f, "R7 mask readback");
    pulse(7'h12);
    check({15'b0, irq}, 16'h1, "R6 irq raised");
    read(8'h08, 16'h0012, "R2 status nack+tx");
    read(8'h28, 16'h0002, "R8 vector nack first");
    read(8'h28, 16'h0005, "R10 vector tx next");
    read(8'h28, 16'h0000, "R9 vector drained");
    check({15'b0, irq}, 16'h0, "R6 irq dropped");
    read(8'h08, 16'h0000, "R10 status cleared");

    // R9 masked source not reported
    write(8'h04, 16'h007e);
    pulse(7'h21);
    read(8'h28, 16'h0006, "R9 masked arb skipped");
    check({15'b0, irq}, 16'h0, "R6 masked flag no irq");
    read(8'h08, 16'h0001, "R2 masked arb still set");
    read(8'h28, 16'h0000, "R9 only masked pending");
    write(8'h08, 16'h0001);

    // R4 write-1-clear
    pulse(7'h0c);
    read(8'h08, 16'h000c, "R2 status ardy+rrdy");
    write(8'h08, 16'h0004);
    read(8'h08, 16'h0008, "R4 one bit cleared");
    write(8'h08, 16'h0000);
    read(8'h08, 16'h0008, "R4 zero write no effect");
    check({15'b0, irq}, 16'h1, "R6 rrdy enabled irq");

    // R5 set wins over clear
    evt = 7'h40; wr = 1'b1; addr = 8'h08; wdata = 16'h0040;
    @(negedge clk);
    evt = '0; wr = 1'b0;
    read(8'h08, 16'h0048, "R5 event beats clear");

    // R3 level bits
    busy = 1'b1; rsfull = 1'b1;
    write(8'h04, 16'h0000);
    read(8'h08, 16'h1848, "R3 busy rsfull shown");
    check({15'b0, irq}, 16'h0, "R6 levels no irq");
    write(8'h08, 16'h1800);
    read(8'h08, 16'h1848, "R3 level bits not writable");
    read(8'h28, 16'h0000, "R9 all masked");
    busy = 1'b0; rsfull = 1'b0;
    read(8'h08, 16'h0048, "R3 levels follow inputs");

    // R11 unmapped, R8 code 7
    read(8'h10, 16'h0000, "R11 unmapped offset");
    write(8'h04, 16'h0055);
    read(8'h28, 16'h0007, "R8 slave code");
    read(8'h08, 16'h0008, "R10 slave flag cleared");
    read(8'h04, 16'h0055, "R7 mask holds");

    repeat (3) @(negedge clk);
    check(16'(exp_q.size()), 16'h0, "R11 all reads returned");
    finish_run();
  end
endmodule